// File: doc/BRIEF.md
# Fault collection and reaction unit

This block collects fault indications from on-chip safety monitors. Examples are the bus ECC checkers, a memory-protection monitor, core machine-check lines and PLL loss-of-lock detectors. Each fault has a fixed number. The block latches fault number `n` into a sticky status bit at word `n / 32`, bit `n % 32`. Every fault also has its own configuration:

- an enable that gates recording;
- a reaction select, which chooses between a reset request to the reset generator and an interrupt request to the interrupt controller;
- an interrupt enable.

Software uses a small synchronous register port. It reads the status words and clears recorded faults by writing ones. A clear must follow recovery of the source. A fault input that is still high keeps its bit set. Every input is sampled on the clock. No fault depends on a software injection path, so faults that software cannot provoke are recorded in the same way as all the others.

Top module: `fcr_top`

## Requirements
- R1: Fault input `n` sets status word `n/32`, bit `n%32`, on the clock edge where it is seen high. For example, fault 34 sets word 1 bit 2, fault 49 sets word 1 bit 17 and fault 84 sets word 2 bit 20. No other status bit changes.
- R2: A status bit stays set after its fault input returns low.
- R3: Writing the status bank (`reg_addr_i[ADDR_W-1:ADDR_W-2]` = 0, low bits = word index) clears each bit where the write data holds a one. Bits written with zero keep their value.
- R4: If a fault input is high in the same cycle as a clear of its bit, the bit stays set.
- R5: A fault input that is high for a single clock cycle is enough to set its status bit.
- R6: A fault whose enable bit is 0 sets no status bit and raises neither a reset request nor an interrupt request. The enable bank is 1.
- R7: `rst_req_o` is high for exactly one cycle, the cycle after an enabled fault whose reaction-select bit is 1 (bank 2) rises. A held input gives only one pulse.
- R8: `irq_o` is high while any set status bit has reaction select 0 and interrupt enable 1 (bank 3). It drops in the cycle after the last such bit is cleared or masked.
- R9: Faults 49 and 50 are independent inputs. Each sets only its own bit.
- R10: After reset, all status bits, `rst_req_o` and `irq_o` are 0. The enable and interrupt-enable banks are all ones, and the reaction-select bank is all zeros.
- R11: Reads of the enable, reaction-select and interrupt-enable banks return the last value written. Bits at or above `NUM_FAULTS` read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| fault_i | input | NUM_FAULTS | Fault indications, bit n is fault number n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Bank select in the top two bits, word index below |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Level interrupt request |

## Verification
Single-cycle pulses on faults 34, 49 and 84 show whether word and bit indexing are correct across three different words. Pulses on 49 and then 50 show whether neighbouring PLL inputs are kept apart. A fault held through a clear separates a true write-one-to-clear from a clear that overrides a live source. A held reset-configured fault shows whether the reset request is an edge pulse or a level. Masking, disabling and re-enabling a fault show whether the interrupt level follows the configuration and whether a disabled fault leaves any trace.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        BANK_STATUS = 2'd0,
        BANK_ENABLE = 2'd1,
        BANK_RSEL   = 2'd2,
        BANK_IRQEN  = 2'd3
    } bank_e;
endpackage

// File: rtl/fcr_status_word.sv
module fcr_status_word #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] fault_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] status_d, status_q;

    always_comb begin
        status_d = (status_q & ~clr_i) | (fault_i & en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= status_d;
    end

    assign status_o = status_q;

    // R2: a set bit that was not cleared remains set
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_q & ($past(status_q) & ~$past(clr_i))) == ($past(status_q) & ~$past(clr_i))));

    // R5 / R4: an enabled fault seen high is recorded next cycle, clear or not
    p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_q & $past(fault_i & en_i)) == $past(fault_i & en_i)));

    // R6: a disabled fault never raises a bit
    p_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((status_q & ~$past(status_q)) & ~$past(en_i)) == '0));
endmodule

// File: rtl/fcr_reaction.sv
module fcr_reaction #(
    parameter int unsigned N = 96
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] fault_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] rsel_i,
    input  logic [N-1:0] ien_i,
    input  logic [N-1:0] status_i,
    output logic         rst_req_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic         rst_req;
    } react_t;

    react_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.prev    = fault_i;
        st_d.rst_req = |(fault_i & ~st_q.prev & en_i & rsel_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_req_o = st_q.rst_req;
    assign irq_o     = |(status_i & ~rsel_i & ien_i);

    // R7: every reset request is caused by an enabled reset-configured fault
    p_rst_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> $past(|(fault_i & en_i & rsel_i)));

    // R7: a held input does not give a second pulse
    p_rst_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o && $stable(fault_i)) |=> !rst_req_o);

    // R8: no interrupt without a recorded fault
    p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|status_i));
endmodule

// File: rtl/fcr_top.sv
module fcr_top #(
    parameter int unsigned NUM_FAULTS = 96,
    localparam int unsigned NUM_WORDS = (NUM_FAULTS + 31) / 32,
    localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned ADDR_W    = IDX_W + 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic                  rst_req_o,
    output logic                  irq_o
);
    import fcr_pkg::*;

    localparam int unsigned TOTAL = NUM_WORDS * WORD_W;
    localparam logic [TOTAL-1:0] VALID_MASK = {TOTAL{1'b1}} >> (TOTAL - NUM_FAULTS);
    localparam logic [IDX_W:0]   NW_L = NUM_WORDS[IDX_W:0];

    typedef struct packed {
        logic [TOTAL-1:0] en;
        logic [TOTAL-1:0] rsel;
        logic [TOTAL-1:0] ien;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [TOTAL-1:0] clr;
    logic [TOTAL-1:0] fault_w;
    logic [TOTAL-1:0] status_w;
    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic [IDX_W+4:0] base;

    assign bank   = bank_e'(reg_addr_i[ADDR_W-1 -: 2]);
    assign idx    = reg_addr_i[IDX_W-1:0];
    assign idx_ok = ({1'b0, idx} < NW_L);
    assign base   = {idx, 5'b0};

    always_comb begin
        fault_w = '0;
        fault_w[NUM_FAULTS-1:0] = fault_i;
    end

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (reg_we_i && idx_ok) begin
            unique case (bank)
                BANK_STATUS: clr[base +: WORD_W]        = reg_wdata_i;
                BANK_ENABLE: cfg_d.en[base +: WORD_W]   = reg_wdata_i;
                BANK_RSEL:   cfg_d.rsel[base +: WORD_W] = reg_wdata_i;
                BANK_IRQEN:  cfg_d.ien[base +: WORD_W]  = reg_wdata_i;
                default: ;
            endcase
        end
        cfg_d.en   = cfg_d.en   & VALID_MASK;
        cfg_d.rsel = cfg_d.rsel & VALID_MASK;
        cfg_d.ien  = cfg_d.ien  & VALID_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.en   <= VALID_MASK;
            cfg_q.rsel <= '0;
            cfg_q.ien  <= VALID_MASK;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (idx_ok) begin
            unique case (bank)
                BANK_STATUS: reg_rdata_o = status_w[base +: WORD_W];
                BANK_ENABLE: reg_rdata_o = cfg_q.en[base +: WORD_W];
                BANK_RSEL:   reg_rdata_o = cfg_q.rsel[base +: WORD_W];
                BANK_IRQEN:  reg_rdata_o = cfg_q.ien[base +: WORD_W];
                default: ;
            endcase
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        fcr_status_word #(.W(WORD_W)) i_word (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .fault_i  (fault_w[w*WORD_W +: WORD_W]),
            .en_i     (cfg_q.en[w*WORD_W +: WORD_W]),
            .clr_i    (clr[w*WORD_W +: WORD_W]),
            .status_o (status_w[w*WORD_W +: WORD_W])
        );
    end

    fcr_reaction #(.N(TOTAL)) i_reaction (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fault_i   (fault_w),
        .en_i      (cfg_q.en),
        .rsel_i    (cfg_q.rsel),
        .ien_i     (cfg_q.ien),
        .status_i  (status_w),
        .rst_req_o (rst_req_o),
        .irq_o     (irq_o)
    );

    // R11: bits beyond the fault count never hold configuration
    p_cfg_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cfg_q.en | cfg_q.rsel | cfg_q.ien) & ~VALID_MASK) == '0);
endmodule

// File: tb/test_fcr_top.sv
module test_fcr_top;
    localparam int NF = 96;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] fault = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rst_req, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fcr_top #(.NUM_FAULTS(NF)) i_fcr_top (
        .clk_i(clk), .rst_ni(rst_n), .fault_i(fault),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .rst_req_o(rst_req), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int bank, int idx, logic [31:0] d);
        @(negedge clk);
        addr = AW'((bank << 2) | idx); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int bank, int idx, output logic [31:0] d);
        addr = AW'((bank << 2) | idx);
        #1 d = rdata;
    endtask

    task automatic pulse(int n);
        @(negedge clk); fault[n] = 1'b1;
        @(negedge clk); fault[n] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int w = 0; w < 3; w++) begin
            rd(0, w, d); check("R10 status", d, 32'h0);
            rd(1, w, d); check("R10 enable", d, 32'hFFFF_FFFF);
            rd(2, w, d); check("R10 rsel", d, 32'h0);
            rd(3, w, d); check("R10 irqen", d, 32'hFFFF_FFFF);
        end
        check("R10 rst_req", {31'b0, rst_req}, 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map(int n);
        logic [31:0] d;
        pulse(n);
        for (int w = 0; w < 3; w++) begin
            rd(0, w, d);
            check("R1 R2 R5 map", d, (w == n / 32) ? (32'h1 << (n % 32)) : 32'h0);
        end
        check("R8 irq up", {31'b0, irq}, 32'h1);
        wr(0, n / 32, 32'h0);
        rd(0, n / 32, d); check("R3 zero write", d, 32'h1 << (n % 32));
        wr(0, n / 32, 32'h1 << (n % 32));
        rd(0, n / 32, d); check("R3 clear", d, 32'h0);
        check("R8 irq down", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_pll();
        logic [31:0] d;
        pulse(49);
        rd(0, 1, d); check("R9 only 49", d, 32'h0002_0000);
        pulse(50);
        rd(0, 1, d); check("R9 both", d, 32'h0006_0000);
        wr(0, 1, 32'h0002_0000);
        rd(0, 1, d); check("R9 clear 49 only", d, 32'h0004_0000);
        wr(0, 1, 32'hFFFF_FFFF);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        @(negedge clk); fault[10] = 1'b1;
        wr(0, 0, 32'h400);
        rd(0, 0, d); check("R4 held stays", d, 32'h400);
        fault[10] = 1'b0;
        @(negedge clk);
        wr(0, 0, 32'h400);
        rd(0, 0, d); check("R4 clear after recovery", d, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        int pulses = 0;
        wr(2, 0, 32'h20);
        wr(1, 0, ~32'h20);
        @(negedge clk); fault[5] = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        fault[5] = 1'b0;
        rd(0, 0, d); check("R6 no status", d, 32'h0);
        check("R6 no rst", 32'(pulses), 32'h0);
        check("R6 no irq", {31'b0, irq}, 32'h0);
        wr(1, 0, 32'hFFFF_FFFF);
        wr(2, 0, 32'h0);
    endtask

    task automatic t_rst_pulse();
        logic [31:0] d;
        int pulses = 0;
        logic first;
        wr(2, 2, 32'h0010_0000);
        @(negedge clk); fault[84] = 1'b1;
        @(negedge clk); first = rst_req;
        if (rst_req) pulses++;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (rst_req) pulses++;
        end
        fault[84] = 1'b0;
        check("R7 pulse timing", {31'b0, first}, 32'h1);
        check("R7 one pulse", 32'(pulses), 32'h1);
        check("R8 no irq for reset fault", {31'b0, irq}, 32'h0);
        rd(0, 2, d); check("R1 fault 84", d, 32'h0010_0000);
        @(negedge clk);
        wr(0, 2, 32'hFFFF_FFFF);
        wr(2, 2, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(3, 1, ~32'h4);
        pulse(34);
        rd(0, 1, d); check("R8 masked status", d, 32'h4);
        check("R8 masked irq", {31'b0, irq}, 32'h0);
        wr(3, 1, 32'hFFFF_FFFF);
        check("R8 unmasked irq", {31'b0, irq}, 32'h1);
        wr(0, 1, 32'h4);
        check("R8 cleared irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        wr(2, 1, 32'hA5A5_A5A5);
        rd(2, 1, d); check("R11 rsel readback", d, 32'hA5A5_A5A5);
        wr(3, 0, 32'h1234_5678);
        rd(3, 0, d); check("R11 irqen readback", d, 32'h1234_5678);
        wr(2, 1, 32'h0);
        wr(3, 0, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map(34);
        t_map(49);
        t_map(84);
        t_pll();
        t_hold();
        t_disable();
        t_rst_pulse();
        t_mask();
        t_cfg();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule